// File: doc/BRIEF.md
# IDE DMA Chunk Sequencer

This block drives one IDE DMA command through a descriptor-driven DMA engine that hands it memory segments one at a time. When a command starts, the sequencer arms itself and loads the number of bytes still to move. That count is the sector count times 512 for a disk, or the packet transfer size for a packet (CD) device. It clears its running byte index and kicks the DMA engine. For every segment (memory address and length) the engine presents, the sequencer works out the byte offset on the storage medium. It sends one read, write or trim request to the storage port. It charges the segment against the remaining count and the index, and waits for the storage response. It then either releases the segment and waits for the next one, or completes the command.

A disk command completes by writing the ready-and-seek status and pulsing the disk interrupt. A packet command completes by pulsing a packet-OK strobe. Packet commands whose block address is all ones are not block transfers. For these the sequencer asks for a single copy from its internal buffer into the segment and finishes. A segment that arrives before the command is armed is handed back unprocessed, so the DMA engine can present it again later. A flush request is answered only when no storage request is outstanding.

The controller has three named states. S_IDLE waits for a start or a segment. S_EVAL judges the latched segment. S_WAIT waits for the storage response. The transitions are:
- S_IDLE to S_EVAL when a segment arrives while armed.
- S_EVAL to S_WAIT when a storage request is issued.
- S_EVAL to S_IDLE when the command finishes, the segment is empty, a non-block copy is made or the command type is bad.
- S_WAIT to S_EVAL on a good response.
- S_WAIT to S_IDLE on an error response.

Top module: `ide_dma_sequencer`

## Requirements
- R1: After reset, `active`, `dev_status`, `dev_irq`, `st_req`, `seg_release`, `seg_skip`, `pkt_ok`, `cmd_err` and `flush_done` are all 0.
- R2: A `cmd_start` pulse in S_IDLE does four things. It sets `active`. It pulses `dma_kick` one cycle later. It loads the remaining count with `cmd_count`×512 (disk, `cmd_packet`=0) or `cmd_pkt_bytes` (packet). It clears the byte index. For a disk command, `dev_status` becomes 0x80.
- R3: A segment presented while `active` is 0 produces a single `seg_skip` pulse, no storage request, and leaves `active` at 0.
- R4: A non-empty segment on an armed block command issues one `st_req` pulse. Its `st_addr` and `st_len` equal the segment's address and length. Its `st_offset` is (`cmd_sector`×512 or `cmd_lba`×2048) plus the bytes issued earlier in the command.
- R5: `st_op` encodes the request. A disk command with `cmd_kind` 0 gives 0 (read), kind 1 gives 1 (write) and kind 2 gives 2 (trim). A packet command always gives 0. A disk command with kind 3 issues no request and instead pulses `cmd_err`, pulses `seg_release`, clears `active` and sets `dev_status` to 0x51.
- R6: After a good response, a remaining count above zero gives a `seg_release` pulse with `active` still 1. A remaining count of zero or below completes the command. This includes the case where the segment was longer than the remaining count.
- R7: Disk completion sets `dev_status` to 0x50, pulses `dev_irq` and `seg_release`, and clears `active`. Packet completion pulses `pkt_ok` and `seg_release` and clears `active`.
- R8: A zero-length segment pulses `seg_release`, issues no request and leaves `active` at 1.
- R9: For a packet command with `cmd_lba` all ones, a segment issues no request. Instead it pulses `copy_req` with `copy_len` = min(remaining, segment length) and `copy_addr` = segment address. It also pulses `pkt_ok` and `seg_release`, and clears `active`.
- R10: An error response (`st_resp` with `st_err`) pulses `cmd_err` and `seg_release` and clears `active`. For a disk command it also sets `dev_status` to 0x51.
- R11: Only one storage request is outstanding at a time. `flush_done` pulses once per flush request, and only when no request is outstanding. A flush made while waiting for a response is answered after that response. A flush made while idle is answered the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start-of-command pulse |
| cmd_packet | input | 1 | 1 = packet (2048-byte block) device, 0 = disk |
| cmd_kind | input | 2 | Disk command type: 0 read, 1 write, 2 trim, 3 invalid |
| cmd_count | input | SEC_W | Disk sector count |
| cmd_pkt_bytes | input | CNT_W | Packet transfer size in bytes |
| cmd_sector | input | LBA_W | Disk starting sector number |
| cmd_lba | input | LBA_W | Packet block address; all ones = non-block transfer |
| dma_kick | output | 1 | Pulse telling the DMA engine to run |
| active | output | 1 | Command armed |
| seg_valid | input | 1 | Segment presented (one-cycle pulse) |
| seg_addr | input | ADDR_W | Segment memory address |
| seg_len | input | CNT_W | Segment length in bytes |
| seg_skip | output | 1 | Segment not processed, present again later |
| seg_release | output | 1 | Segment finished and handed back |
| st_req | output | 1 | Storage request pulse |
| st_op | output | 2 | Storage operation: 0 read, 1 write, 2 trim |
| st_offset | output | LBA_W+12 | Storage byte offset |
| st_addr | output | ADDR_W | Memory address of the request |
| st_len | output | CNT_W | Byte length of the request |
| st_resp | input | 1 | Storage response pulse |
| st_err | input | 1 | Response carries an error |
| copy_req | output | 1 | Internal-buffer copy pulse (non-block) |
| copy_addr | output | ADDR_W | Copy destination address |
| copy_len | output | CNT_W | Copy length in bytes |
| pkt_ok | output | 1 | Packet command completed OK |
| cmd_err | output | 1 | Command ended with error |
| dev_status | output | 8 | Disk status byte |
| dev_irq | output | 1 | Disk completion interrupt pulse |
| flush_req | input | 1 | Flush request pulse |
| flush_done | output | 1 | Flush answered |

## Verification
The hardest case to reach is a flush that arrives while a storage request is still in flight. The bench presents a segment and lets the request go out. It then holds back the storage response while it pulses `flush_req`, checks that no `flush_done` appears over several cycles, and finally returns the response. A second hard case is a segment longer than the remaining count, which drives that count below zero. The bench gets there by giving a packet command a small transfer size and a full 2048-byte segment.

// File: rtl/ide_seq_pkg.sv
package ide_seq_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_EVAL = 2'd1,
        S_WAIT = 2'd2
    } seq_state_e;

    localparam logic [1:0] OP_READ  = 2'd0;
    localparam logic [1:0] OP_BAD   = 2'd3;

    localparam logic [7:0] ST_BUSY  = 8'h80;
    localparam logic [7:0] ST_DONE  = 8'h50;
    localparam logic [7:0] ST_FAULT = 8'h51;

    localparam int DISK_SHIFT = 9;
    localparam int PKT_SHIFT  = 11;
endpackage

// File: rtl/ide_seq_tally.sv
module ide_seq_tally #(
    parameter int CNT_W = 26
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [CNT_W-1:0]        load_bytes,
    input  logic                    consume,
    input  logic [CNT_W-1:0]        amt,
    output logic [CNT_W:0]          index,
    output logic                    exhausted,
    output logic [CNT_W-1:0]        clip_len
);
    logic signed [CNT_W:0] remain_q;
    logic        [CNT_W:0] index_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            index_q  <= '0;
        end else if (load) begin
            remain_q <= $signed({1'b0, load_bytes});
            index_q  <= '0;
        end else if (consume) begin
            remain_q <= remain_q - $signed({1'b0, amt});
            index_q  <= index_q + {1'b0, amt};
        end
    end

    always_comb begin
        index     = index_q;
        exhausted = (remain_q <= 0);
        clip_len  = ($signed({1'b0, amt}) < remain_q) ? amt : remain_q[CNT_W-1:0];
    end
endmodule

// File: rtl/ide_seq_offset.sv
module ide_seq_offset
    import ide_seq_pkg::*;
#(
    parameter int LBA_W = 32,
    parameter int CNT_W = 26,
    parameter int OFF_W = LBA_W + PKT_SHIFT + 1
) (
    input  logic              packet,
    input  logic [LBA_W-1:0]  sector,
    input  logic [LBA_W-1:0]  lba,
    input  logic [CNT_W:0]    index,
    output logic [OFF_W-1:0]  offset
);
    logic [OFF_W-1:0] base;

    always_comb begin
        if (packet) base = OFF_W'(lba) << PKT_SHIFT;
        else        base = OFF_W'(sector) << DISK_SHIFT;
        offset = base + OFF_W'(index);
    end
endmodule

// File: rtl/ide_dma_sequencer.sv
module ide_dma_sequencer
    import ide_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 26,
    parameter int SEC_W  = 16,
    parameter int LBA_W  = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_start,
    input  logic                        cmd_packet,
    input  logic [1:0]                  cmd_kind,
    input  logic [SEC_W-1:0]            cmd_count,
    input  logic [CNT_W-1:0]            cmd_pkt_bytes,
    input  logic [LBA_W-1:0]            cmd_sector,
    input  logic [LBA_W-1:0]            cmd_lba,
    output logic                        dma_kick,
    output logic                        active,
    input  logic                        seg_valid,
    input  logic [ADDR_W-1:0]           seg_addr,
    input  logic [CNT_W-1:0]            seg_len,
    output logic                        seg_skip,
    output logic                        seg_release,
    output logic                        st_req,
    output logic [1:0]                  st_op,
    output logic [LBA_W+PKT_SHIFT:0]    st_offset,
    output logic [ADDR_W-1:0]           st_addr,
    output logic [CNT_W-1:0]            st_len,
    input  logic                        st_resp,
    input  logic                        st_err,
    output logic                        copy_req,
    output logic [ADDR_W-1:0]           copy_addr,
    output logic [CNT_W-1:0]            copy_len,
    output logic                        pkt_ok,
    output logic                        cmd_err,
    output logic [7:0]                  dev_status,
    output logic                        dev_irq,
    input  logic                        flush_req,
    output logic                        flush_done
);
    localparam int OFF_W = LBA_W + PKT_SHIFT + 1;

    seq_state_e state_q, state_d;

    logic               pkt_q;
    logic [1:0]         kind_q;
    logic [LBA_W-1:0]   sector_q, lba_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [CNT_W-1:0]   len_q;
    logic               flush_pend_q;

    logic [CNT_W:0]     index;
    logic               exhausted;
    logic [CNT_W-1:0]   clip_len;
    logic [OFF_W-1:0]   offset;

    logic start_now, take_seg, skip_seg;
    logic ev_finish, ev_empty, ev_nonblock, ev_bad, issue_now;
    logic flush_pend, req_busy;
    logic [CNT_W-1:0] load_bytes;

    always_comb begin
        start_now   = (state_q == S_IDLE) && cmd_start;
        take_seg    = (state_q == S_IDLE) && seg_valid && active;
        skip_seg    = (state_q == S_IDLE) && seg_valid && !active;
        ev_finish   = exhausted;
        ev_empty    = (len_q == '0);
        ev_nonblock = pkt_q && (&lba_q);
        ev_bad      = !pkt_q && (kind_q == OP_BAD);
        issue_now   = (state_q == S_EVAL) && !ev_finish && !ev_empty
                      && !ev_nonblock && !ev_bad;
        load_bytes  = cmd_packet ? cmd_pkt_bytes
                                 : (CNT_W'(cmd_count) << DISK_SHIFT);
        flush_pend  = flush_pend_q || flush_req;
        req_busy    = (state_q == S_WAIT) || issue_now;
    end

    ide_seq_tally #(.CNT_W(CNT_W)) u_tally (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start_now),
        .load_bytes (load_bytes),
        .consume    (issue_now),
        .amt        (len_q),
        .index      (index),
        .exhausted  (exhausted),
        .clip_len   (clip_len)
    );

    ide_seq_offset #(.LBA_W(LBA_W), .CNT_W(CNT_W), .OFF_W(OFF_W)) u_offset (
        .packet (pkt_q),
        .sector (sector_q),
        .lba    (lba_q),
        .index  (index),
        .offset (offset)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (take_seg) state_d = S_EVAL;
            S_EVAL: state_d = issue_now ? S_WAIT : S_IDLE;
            S_WAIT: if (st_resp) state_d = st_err ? S_IDLE : S_EVAL;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and datapath latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active       <= 1'b0;
            dma_kick     <= 1'b0;
            seg_skip     <= 1'b0;
            seg_release  <= 1'b0;
            st_req       <= 1'b0;
            st_op        <= OP_READ;
            st_offset    <= '0;
            st_addr      <= '0;
            st_len       <= '0;
            copy_req     <= 1'b0;
            copy_addr    <= '0;
            copy_len     <= '0;
            pkt_ok       <= 1'b0;
            cmd_err      <= 1'b0;
            dev_status   <= 8'h00;
            dev_irq      <= 1'b0;
            flush_done   <= 1'b0;
            flush_pend_q <= 1'b0;
            pkt_q        <= 1'b0;
            kind_q       <= OP_READ;
            sector_q     <= '0;
            lba_q        <= '0;
            addr_q       <= '0;
            len_q        <= '0;
        end else begin
            dma_kick    <= 1'b0;
            seg_skip    <= 1'b0;
            seg_release <= 1'b0;
            st_req      <= 1'b0;
            copy_req    <= 1'b0;
            pkt_ok      <= 1'b0;
            cmd_err     <= 1'b0;
            dev_irq     <= 1'b0;
            flush_done  <= 1'b0;

            if (start_now) begin
                active   <= 1'b1;
                dma_kick <= 1'b1;
                pkt_q    <= cmd_packet;
                kind_q   <= cmd_kind;
                sector_q <= cmd_sector;
                lba_q    <= cmd_lba;
                if (!cmd_packet) dev_status <= ST_BUSY;
            end
            if (skip_seg) seg_skip <= 1'b1;
            if (take_seg) begin
                addr_q <= seg_addr;
                len_q  <= seg_len;
            end

            unique case (state_q)
                S_EVAL: begin
                    if (ev_finish) begin
                        active      <= 1'b0;
                        seg_release <= 1'b1;
                        if (pkt_q) pkt_ok <= 1'b1;
                        else begin
                            dev_status <= ST_DONE;
                            dev_irq    <= 1'b1;
                        end
                    end else if (ev_empty) begin
                        seg_release <= 1'b1;
                    end else if (ev_nonblock) begin
                        copy_req    <= 1'b1;
                        copy_addr   <= addr_q;
                        copy_len    <= clip_len;
                        len_q       <= '0;
                        pkt_ok      <= 1'b1;
                        active      <= 1'b0;
                        seg_release <= 1'b1;
                    end else if (ev_bad) begin
                        cmd_err     <= 1'b1;
                        active      <= 1'b0;
                        seg_release <= 1'b1;
                        dev_status  <= ST_FAULT;
                    end else begin
                        st_req    <= 1'b1;
                        st_op     <= pkt_q ? OP_READ : kind_q;
                        st_offset <= offset;
                        st_addr   <= addr_q;
                        st_len    <= len_q;
                        len_q     <= '0;
                    end
                end
                S_WAIT: begin
                    if (st_resp && st_err) begin
                        cmd_err     <= 1'b1;
                        active      <= 1'b0;
                        seg_release <= 1'b1;
                        if (!pkt_q) dev_status <= ST_FAULT;
                    end
                end
                default: ;
            endcase

            if (flush_pend && !req_busy) begin
                flush_done   <= 1'b1;
                flush_pend_q <= 1'b0;
            end else begin
                flush_pend_q <= flush_pend;
            end
        end
    end

    // outstanding-request tracker used by the assertions
    logic outst_q;
    always_ff @(posedge clk) begin
        if (!rst_n)       outst_q <= 1'b0;
        else if (st_req)  outst_q <= 1'b1;
        else if (st_resp) outst_q <= 1'b0;
    end

    // R2
    kick_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_kick |-> active);
    // R3
    skip_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_skip |-> !$past(active) && !st_req);
    // R4
    seg_outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({seg_skip, seg_release, st_req}));
    // R5
    op_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_req |-> st_op != OP_BAD);
    // R7
    disk_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_irq |-> dev_status == ST_DONE && !active && seg_release);
    // R9
    nonblock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        copy_req |-> pkt_ok && !active && !st_req);
    // R10
    err_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> !active && seg_release);
    // R11
    single_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_req |-> !outst_q);
    // R11
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |-> !outst_q && !st_req);
endmodule

// File: tb/ide_dma_sequencer_test.sv
`timescale 1ns/1ps
module ide_dma_sequencer_test;
    localparam int ADDR_W = 32, CNT_W = 26, SEC_W = 16, LBA_W = 32;

    logic clk = 0, rst_n = 0;
    logic cmd_start = 0, cmd_packet = 0;
    logic [1:0] cmd_kind = 0;
    logic [SEC_W-1:0] cmd_count = 0;
    logic [CNT_W-1:0] cmd_pkt_bytes = 0;
    logic [LBA_W-1:0] cmd_sector = 0, cmd_lba = 0;
    logic dma_kick, active;
    logic seg_valid = 0;
    logic [ADDR_W-1:0] seg_addr = 0;
    logic [CNT_W-1:0] seg_len = 0;
    logic seg_skip, seg_release, st_req;
    logic [1:0] st_op;
    logic [LBA_W+11:0] st_offset;
    logic [ADDR_W-1:0] st_addr;
    logic [CNT_W-1:0] st_len;
    logic st_resp = 0, st_err = 0;
    logic copy_req;
    logic [ADDR_W-1:0] copy_addr;
    logic [CNT_W-1:0] copy_len;
    logic pkt_ok, cmd_err, dev_irq, flush_done;
    logic [7:0] dev_status;
    logic flush_req = 0;

    always #4 clk = ~clk;

    ide_dma_sequencer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SEC_W(SEC_W), .LBA_W(LBA_W)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_packet(cmd_packet),
        .cmd_kind(cmd_kind), .cmd_count(cmd_count), .cmd_pkt_bytes(cmd_pkt_bytes),
        .cmd_sector(cmd_sector), .cmd_lba(cmd_lba), .dma_kick(dma_kick), .active(active),
        .seg_valid(seg_valid), .seg_addr(seg_addr), .seg_len(seg_len),
        .seg_skip(seg_skip), .seg_release(seg_release), .st_req(st_req), .st_op(st_op),
        .st_offset(st_offset), .st_addr(st_addr), .st_len(st_len), .st_resp(st_resp),
        .st_err(st_err), .copy_req(copy_req), .copy_addr(copy_addr), .copy_len(copy_len),
        .pkt_ok(pkt_ok), .cmd_err(cmd_err), .dev_status(dev_status), .dev_irq(dev_irq),
        .flush_req(flush_req), .flush_done(flush_done));

    int total = 0, fails = 0;
    bit finished = 0;

    // event monitor, sampled 2 ns after each rising edge
    int c_kick, c_req, c_rel, c_skip, c_copy, c_ok, c_err, c_irq, c_fd;
    longint l_off, l_op, l_addr, l_len, l_copy, l_caddr;
    always @(posedge clk) begin
        #2;
        if (dma_kick) c_kick++;
        if (st_req) begin
            c_req++; l_off = st_offset; l_op = st_op; l_addr = st_addr; l_len = st_len;
        end
        if (seg_release) c_rel++;
        if (seg_skip) c_skip++;
        if (copy_req) begin c_copy++; l_copy = copy_len; l_caddr = copy_addr; end
        if (pkt_ok) c_ok++;
        if (cmd_err) c_err++;
        if (dev_irq) c_irq++;
        if (flush_done) c_fd++;
    end

    task automatic clr();
        c_kick = 0; c_req = 0; c_rel = 0; c_skip = 0; c_copy = 0;
        c_ok = 0; c_err = 0; c_irq = 0; c_fd = 0;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic start_cmd(input bit pkt, input logic [1:0] kind, input int cnt,
                             input int pbytes, input longint sec, input longint lba);
        @(negedge clk);
        cmd_packet = pkt; cmd_kind = kind; cmd_count = SEC_W'(cnt);
        cmd_pkt_bytes = CNT_W'(pbytes); cmd_sector = LBA_W'(sec); cmd_lba = LBA_W'(lba);
        cmd_start = 1;
        @(negedge clk);
        cmd_start = 0;
        step(1);
    endtask

    task automatic send_seg(input longint addr, input int len);
        @(negedge clk);
        seg_valid = 1; seg_addr = ADDR_W'(addr); seg_len = CNT_W'(len);
        @(negedge clk);
        seg_valid = 0;
        step(3);
    endtask

    task automatic respond(input bit err);
        @(negedge clk);
        st_resp = 1; st_err = err;
        @(negedge clk);
        st_resp = 0; st_err = 0;
        step(3);
    endtask

    task automatic t_reset();
        chk(active == 0, "R1 active", active, 0);
        chk(dev_status == 0, "R1 status", dev_status, 0);
        chk({st_req, seg_release, seg_skip, pkt_ok, cmd_err, flush_done, dev_irq} == 0,
            "R1 strobes", 1, 0);
    endtask

    task automatic t_skip();
        clr();
        send_seg(32'h1000, 512);
        chk(c_skip == 1, "R3 skip pulse", c_skip, 1);
        chk(c_req == 0, "R3 no request", c_req, 0);
        chk(active == 0, "R3 stays idle", active, 0);
    endtask

    task automatic t_disk_read();
        clr();
        start_cmd(0, 2'd0, 2, 0, 100, 0);
        chk(c_kick == 1, "R2 kick", c_kick, 1);
        chk(active == 1, "R2 armed", active, 1);
        chk(dev_status == 8'h80, "R2 busy status", dev_status, 8'h80);
        send_seg(32'h2000, 512);
        chk(c_req == 1, "R4 first request", c_req, 1);
        chk(l_off == 51200, "R4 disk offset 0", l_off, 51200);
        chk(l_addr == 32'h2000 && l_len == 512, "R4 addr/len", l_addr, 32'h2000);
        chk(l_op == 0, "R5 read op", l_op, 0);
        respond(0);
        chk(c_rel == 1 && active == 1, "R6 release, still armed", c_rel, 1);
        send_seg(32'h3000, 512);
        chk(l_off == 51712, "R4 disk offset 1", l_off, 51712);
        respond(0);
        chk(dev_status == 8'h50, "R7 disk done status", dev_status, 8'h50);
        chk(c_irq == 1, "R7 disk irq", c_irq, 1);
        chk(active == 0 && c_rel == 2, "R7 disarmed", active, 0);
    endtask

    task automatic t_ops(input logic [1:0] kind);
        clr();
        start_cmd(0, kind, 1, 0, 7, 0);
        send_seg(32'h4000, 512);
        chk(l_op == kind, "R5 op code", l_op, kind);
        chk(l_off == 3584, "R4 offset", l_off, 3584);
        respond(0);
        chk(c_irq == 1 && active == 0, "R7 completion", c_irq, 1);
    endtask

    task automatic t_bad_kind();
        clr();
        start_cmd(0, 2'd3, 1, 0, 1, 0);
        send_seg(32'h5000, 512);
        chk(c_req == 0, "R5 bad kind no request", c_req, 0);
        chk(c_err == 1 && c_rel == 1, "R5 bad kind error", c_err, 1);
        chk(dev_status == 8'h51, "R5 fault status", dev_status, 8'h51);
        chk(active == 0, "R5 disarmed", active, 0);
    endtask

    task automatic t_zero_len();
        clr();
        start_cmd(0, 2'd0, 1, 0, 0, 0);
        send_seg(32'h6000, 0);
        chk(c_rel == 1 && c_req == 0, "R8 empty segment released", c_rel, 1);
        chk(active == 1, "R8 still armed", active, 1);
        send_seg(32'h6000, 512);
        chk(c_req == 1 && l_off == 0, "R8 later request", l_off, 0);
        respond(0);
        chk(c_irq == 1, "R8 completes", c_irq, 1);
    endtask

    task automatic t_packet();
        clr();
        start_cmd(1, 2'd1, 0, 4096, 0, 10);
        chk(dev_status == 8'h50, "R2 packet leaves status", dev_status, 8'h50);
        send_seg(32'h7000, 2048);
        chk(l_off == 20480 && l_op == 0, "R4 packet offset 0", l_off, 20480);
        respond(0);
        send_seg(32'h8000, 2048);
        chk(l_off == 22528, "R4 packet offset 1", l_off, 22528);
        respond(0);
        chk(c_ok == 1 && c_irq == 0 && active == 0, "R7 packet ok", c_ok, 1);
    endtask

    task automatic t_overrun();
        clr();
        start_cmd(1, 2'd0, 0, 1000, 0, 3);
        send_seg(32'h9000, 2048);
        chk(l_len == 2048, "R6 full segment issued", l_len, 2048);
        respond(0);
        chk(c_ok == 1 && active == 0, "R6 negative remaining completes", c_ok, 1);
    endtask

    task automatic t_nonblock(input int pbytes, input int len, input int exp);
        clr();
        start_cmd(1, 2'd0, 0, pbytes, 0, 64'hFFFF_FFFF);
        send_seg(32'hA000, len);
        chk(c_req == 0, "R9 no storage", c_req, 0);
        chk(c_copy == 1 && l_copy == exp, "R9 copy length", l_copy, exp);
        chk(l_caddr == 32'hA000, "R9 copy addr", l_caddr, 32'hA000);
        chk(c_ok == 1 && active == 0 && c_rel == 1, "R9 ok and disarm", c_ok, 1);
    endtask

    task automatic t_error();
        clr();
        start_cmd(0, 2'd0, 4, 0, 2, 0);
        send_seg(32'hB000, 512);
        respond(1);
        chk(c_err == 1 && c_rel == 1, "R10 error pulse", c_err, 1);
        chk(dev_status == 8'h51, "R10 fault status", dev_status, 8'h51);
        chk(active == 0, "R10 disarmed", active, 0);
    endtask

    task automatic t_flush();
        clr();
        start_cmd(0, 2'd0, 1, 0, 5, 0);
        send_seg(32'hC000, 512);
        @(negedge clk); flush_req = 1;
        @(negedge clk); flush_req = 0;
        step(5);
        chk(c_fd == 0, "R11 flush held while outstanding", c_fd, 0);
        respond(0);
        chk(c_fd == 1, "R11 flush after response", c_fd, 1);
        chk(c_req == 1, "R11 single request", c_req, 1);
        @(negedge clk); flush_req = 1;
        @(negedge clk); flush_req = 0;
        step(1);
        chk(c_fd == 2, "R11 idle flush immediate", c_fd, 2);
    endtask

    initial begin
        clr();
        step(3);
        rst_n = 1;
        step(1);
        t_reset();
        t_skip();
        t_disk_read();
        t_ops(2'd1);
        t_ops(2'd2);
        t_bad_kind();
        t_zero_len();
        t_packet();
        t_overrun();
        t_nonblock(300, 512, 300);
        t_nonblock(900, 100, 100);
        t_error();
        t_skip();
        t_flush();
        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule